// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is a synchronous sequencer that runs external bus transfers on behalf of a processor core. The core raises a one-cycle transfer request. The controller asks for the shared bus and waits for a grant while no other master is driving it. It then runs an address phase that ends on an address-ready handshake, and a data phase that ends on a data-ready handshake. A single-cycle completion pulse goes back to the core after each transfer.

If a request arrives while a transfer is still running, it is held as pending. When the data handshake completes, a pending request starts the next transfer directly, without passing through idle.

While the core holds the bus locked, three things change:
- Arbitration is passed through in one cycle.
- After a transfer the controller parks in a locked hold state with the bus marked occupied.
- A new request goes straight from the locked hold state to an address phase.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high at a rising edge, every output is low after that edge. Any pending request is discarded.
- R2: When idle with no request (neither `xfer_req` nor a stored pending request), all outputs stay low. A request in the idle state raises `bus_req` after the next edge.
- R3: While `bus_req` is high and the bus is not locked, `bus_req` stays high if `bus_grant` is low or `bus_busy_in` is high. When `bus_grant` is high and `bus_busy_in` is low, the controller moves to the address phase (`addr_stb` high, `bus_req` low).
- R4: With `bus_lock` high during arbitration, the controller moves to the address phase whatever `bus_grant` and `bus_busy_in` are.
- R5: The address phase (`addr_stb`) repeats while `addr_rdy` is low, and `data_rdy` has no effect there. With `addr_rdy` high it moves to the data phase (`data_stb`).
- R6: The data phase repeats while `data_rdy` is low. `xfer_done` is high for exactly the one cycle after the edge at which `data_rdy` is sampled high in the data phase.
- R7: When a data phase completes with the bus unlocked and no request (neither `xfer_req` nor a stored pending request), the controller returns to idle with all strobes low.
- R8: When a data phase completes with the bus unlocked and a request present (`xfer_req` high or a stored pending request), `bus_req` is raised after that edge with no idle cycle.
- R9: When a data phase completes with `bus_lock` high and no request (neither `xfer_req` nor a stored pending request), the controller enters a locked hold state. In that state `bus_busy` is high and all strobes are low. Dropping `bus_lock` there returns it to idle.
- R10: In the locked hold state, or at a locked data completion, a request leads directly to the address phase with no arbitration.
- R11: A `xfer_req` pulse during the arbitration, address or data phase is stored. It is served when the running transfer completes.
- R12: `bus_busy` is high exactly in the address phase, the data phase and the locked hold state. At most one of `bus_req`, `addr_stb` and `data_stb` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Transfer request pulse from the core |
| bus_grant | input | 1 | Bus grant from the external arbiter |
| bus_busy_in | input | 1 | Another master occupies the bus |
| bus_lock | input | 1 | Core holds the bus locked |
| addr_rdy | input | 1 | Address phase accepted by the target |
| data_rdy | input | 1 | Data phase accepted by the target |
| bus_req | output | 1 | Bus request, high during arbitration |
| addr_stb | output | 1 | Address phase strobe |
| data_stb | output | 1 | Data phase strobe |
| bus_busy | output | 1 | Bus occupied by this controller |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the controller with the one-hot state register (`STATE_ONEHOT = 1`), so that variant's decode is exercised. The default binary variant is covered by elaborating the RTL on its own. Both variants present the same port behaviour, so the vector walk reaches every state edge under either build: arbitration stalls, chained and locked completions, and the locked hold exit. A reset in the middle of a transfer, with a pending request already stored, checks that the stored request is discarded.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARB   = 3'd1,
      ST_ADDR  = 3'd2,
      ST_DATA  = 3'd3,
      ST_LHOLD = 3'd4
   } ebc_state_e;

   localparam int unsigned EBC_NUM_STATES = 5;
   localparam int unsigned EBC_STATE_W    = 3;
endpackage

// File: rtl/ebc_req_capture.sv
module ebc_req_capture (
   input  logic clk,
   input  logic rst,
   input  logic req_in,
   input  logic consume,
   output logic req_eff
);
   logic pend_q;

   // A pulse that is not consumed in its own cycle waits for the next slot.
   assign req_eff = pend_q | req_in;

   always_ff @(posedge clk) begin
      if (rst)
         pend_q <= 1'b0;
      else
         pend_q <= req_eff & ~consume;
   end
endmodule

// File: rtl/ebc_next_state.sv
module ebc_next_state
   import ebc_pkg::*;
(
   input  ebc_state_e cur,
   input  logic       req_eff,
   input  logic       grant,
   input  logic       busy_in,
   input  logic       lock,
   input  logic       addr_rdy,
   input  logic       data_rdy,
   output ebc_state_e nxt,
   output logic       consume,
   output logic       complete
);
   logic bus_free;

   assign bus_free = grant & ~busy_in;
   assign complete = (cur == ST_DATA) & data_rdy;

   always_comb begin
      nxt     = cur;
      consume = 1'b0;
      unique case (cur)
         ST_IDLE: begin
            if (req_eff) begin
               nxt     = ST_ARB;
               consume = 1'b1;
            end
         end
         ST_ARB: begin
            if (bus_free || lock) nxt = ST_ADDR;
         end
         ST_ADDR: begin
            if (addr_rdy) nxt = ST_DATA;
         end
         ST_DATA: begin
            if (data_rdy) begin
               consume = req_eff;
               if (lock)
                  nxt = req_eff ? ST_ADDR : ST_LHOLD;
               else
                  nxt = req_eff ? ST_ARB : ST_IDLE;
            end
         end
         ST_LHOLD: begin
            if (!lock) begin
               nxt = ST_IDLE;
            end else if (req_eff) begin
               nxt     = ST_ADDR;
               consume = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/ebc_state_reg.sv
module ebc_state_reg
   import ebc_pkg::*;
#(
   parameter int unsigned STATE_ONEHOT = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  ebc_state_e nxt,
   output ebc_state_e cur
);
   localparam int unsigned OH_W = EBC_NUM_STATES;

   generate
      if (STATE_ONEHOT > 1) begin : g_bad_param
         $error("ebc_state_reg: STATE_ONEHOT must be 0 or 1");
      end

      if (STATE_ONEHOT == 1) begin : g_onehot
         logic [OH_W-1:0] oh_q;

         always_ff @(posedge clk) begin
            if (rst)
               oh_q <= OH_W'(1) << ST_IDLE;
            else
               oh_q <= OH_W'(1) << nxt;
         end

         always_comb begin
            cur = ST_IDLE;
            for (int i = 0; i < OH_W; i++)
               if (oh_q[i]) cur = ebc_state_e'(EBC_STATE_W'(i));
         end
      end else begin : g_binary
         ebc_state_e st_q;

         always_ff @(posedge clk) begin
            if (rst)
               st_q <= ST_IDLE;
            else
               st_q <= nxt;
         end

         assign cur = st_q;
      end
   endgenerate
endmodule

// File: rtl/ebc_out_reg.sv
module ebc_out_reg
   import ebc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  ebc_state_e nxt,
   input  logic       complete,
   output logic       bus_req,
   output logic       addr_stb,
   output logic       data_stb,
   output logic       bus_busy,
   output logic       xfer_done
);
   always_ff @(posedge clk) begin
      if (rst) begin
         bus_req   <= 1'b0;
         addr_stb  <= 1'b0;
         data_stb  <= 1'b0;
         bus_busy  <= 1'b0;
         xfer_done <= 1'b0;
      end else begin
         bus_req   <= (nxt == ST_ARB);
         addr_stb  <= (nxt == ST_ADDR);
         data_stb  <= (nxt == ST_DATA);
         bus_busy  <= (nxt == ST_ADDR) || (nxt == ST_DATA) || (nxt == ST_LHOLD);
         xfer_done <= complete;
      end
   end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebc_pkg::*;
#(
   parameter int unsigned STATE_ONEHOT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic xfer_req,
   input  logic bus_grant,
   input  logic bus_busy_in,
   input  logic bus_lock,
   input  logic addr_rdy,
   input  logic data_rdy,
   output logic bus_req,
   output logic addr_stb,
   output logic data_stb,
   output logic bus_busy,
   output logic xfer_done
);
   ebc_state_e cur_st;
   ebc_state_e nxt_st;
   logic       req_eff;
   logic       consume;
   logic       complete;

   ebc_req_capture u_req (
      .clk     (clk),
      .rst     (rst),
      .req_in  (xfer_req),
      .consume (consume),
      .req_eff (req_eff)
   );

   ebc_next_state u_next (
      .cur      (cur_st),
      .req_eff  (req_eff),
      .grant    (bus_grant),
      .busy_in  (bus_busy_in),
      .lock     (bus_lock),
      .addr_rdy (addr_rdy),
      .data_rdy (data_rdy),
      .nxt      (nxt_st),
      .consume  (consume),
      .complete (complete)
   );

   ebc_state_reg #(.STATE_ONEHOT(STATE_ONEHOT)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   ebc_out_reg u_out (
      .clk       (clk),
      .rst       (rst),
      .nxt       (nxt_st),
      .complete  (complete),
      .bus_req   (bus_req),
      .addr_stb  (addr_stb),
      .data_stb  (data_stb),
      .bus_busy  (bus_busy),
      .xfer_done (xfer_done)
   );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
   input logic clk,
   input logic rst,
   input logic xfer_req,
   input logic bus_grant,
   input logic bus_busy_in,
   input logic bus_lock,
   input logic addr_rdy,
   input logic data_rdy,
   input logic bus_req,
   input logic addr_stb,
   input logic data_stb,
   input logic bus_busy,
   input logic xfer_done
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !(bus_req || addr_stb || data_stb || bus_busy || xfer_done));

   p_arb_stall_r3: assert property (@(posedge clk) disable iff (rst)
      bus_req && !bus_lock && (!bus_grant || bus_busy_in) |=> bus_req);

   p_lock_pass_r4: assert property (@(posedge clk) disable iff (rst)
      bus_req && bus_lock |=> addr_stb);

   p_addr_wait_r5: assert property (@(posedge clk) disable iff (rst)
      addr_stb && !addr_rdy |=> addr_stb);

   p_data_wait_r6: assert property (@(posedge clk) disable iff (rst)
      data_stb && !data_rdy |=> data_stb && !xfer_done);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      data_stb && data_rdy |=> xfer_done && !data_stb);

   p_hold_to_addr_r10: assert property (@(posedge clk) disable iff (rst)
      bus_busy && !addr_stb && !data_stb && bus_lock && xfer_req |=> addr_stb);

   p_phase_excl_r12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({bus_req, addr_stb, data_stb}));

   p_busy_phase_r12: assert property (@(posedge clk) disable iff (rst)
      (addr_stb || data_stb) |-> bus_busy);
endmodule

bind ext_bus_seq ebc_checker u_chk (.*);

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS      = 24;
   localparam int TB_ONEHOT  = 1;

   // row = {req, grant, busy_in, lock, ardy, drdy, exp{bus_req, addr_stb, data_stb, bus_busy, xfer_done}}
   localparam logic [10:0] VEC [NROWS] = '{
      11'b000000_00000, // 0  idle stays idle            R2
      11'b100000_10000, // 1  request -> arbitration     R2
      11'b000000_10000, // 2  no grant, stall            R3
      11'b011000_10000, // 3  granted but busy, stall    R3
      11'b010000_01010, // 4  grant and free -> address  R3
      11'b000001_01010, // 5  addr wait, data_rdy ignored R5
      11'b000010_00110, // 6  addr_rdy -> data           R5
      11'b000000_00110, // 7  data wait                  R6
      11'b000001_00001, // 8  complete -> idle, done     R7
      11'b000000_00000, // 9  done is one cycle          R6
      11'b100000_10000, // 10 request                    R2
      11'b010000_01010, // 11 granted                    R3
      11'b100010_00110, // 12 pulse stored in addr phase R11
      11'b000001_10001, // 13 chained to arbitration     R8
      11'b000100_01010, // 14 lock passes arbitration    R4
      11'b000110_00110, // 15 addr done                  R5
      11'b000101_00011, // 16 locked completion -> hold  R9
      11'b000100_00010, // 17 hold                       R9
      11'b100100_01010, // 18 hold + request -> address  R10
      11'b000110_00110, // 19 addr done                  R12
      11'b100101_01011, // 20 locked chain -> address    R10
      11'b000110_00110, // 21 addr done                  R12
      11'b000101_00011, // 22 back to hold               R9
      11'b000000_00000  // 23 unlock -> idle             R9
   };

   logic clk = 1'b0;
   logic rst, xfer_req, bus_grant, bus_busy_in, bus_lock, addr_rdy, data_rdy;
   logic bus_req, addr_stb, data_stb, bus_busy, xfer_done;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_bus_seq #(.STATE_ONEHOT(TB_ONEHOT)) u_dut (
      .clk(clk), .rst(rst), .xfer_req(xfer_req), .bus_grant(bus_grant),
      .bus_busy_in(bus_busy_in), .bus_lock(bus_lock), .addr_rdy(addr_rdy),
      .data_rdy(data_rdy), .bus_req(bus_req), .addr_stb(addr_stb),
      .data_stb(data_stb), .bus_busy(bus_busy), .xfer_done(xfer_done)
   );

   function automatic string tag_of(int row);
      case (row)
         0, 1, 10:             return "R2";
         2, 3, 4, 11:          return "R3";
         5, 6, 15:             return "R5";
         7, 9:                 return "R6";
         8:                    return "R7";
         12:                   return "R11";
         13:                   return "R8";
         14:                   return "R4";
         16, 17, 22, 23:       return "R9";
         18, 20:               return "R10";
         default:              return "R12";
      endcase
   endfunction

   task automatic check(input string req, input logic [4:0] exp);
      logic [4:0] got;
      got = {bus_req, addr_stb, data_stb, bus_busy, xfer_done};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: outputs %b expected %b", req, got, exp);
      end
   endtask

   // Inputs change at the falling edge; outputs are read at the next falling edge.
   task automatic step(input logic [5:0] in);
      {xfer_req, bus_grant, bus_busy_in, bus_lock, addr_rdy, data_rdy} = in;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      {xfer_req, bus_grant, bus_busy_in, bus_lock, addr_rdy, data_rdy} = '0;
      @(negedge clk);
      @(negedge clk);
      check("R1", 5'b00000);
      rst = 1'b0;

      for (int i = 0; i < NROWS; i++) begin
         step(VEC[i][10:5]);
         check(tag_of(i), VEC[i][4:0]);
      end

      // Reset in the middle of a transfer, with a pending pulse stored (R1).
      step(6'b100000);           // to arbitration
      step(6'b010000);           // to address
      step(6'b100000);           // pulse stored while in address phase
      check("R11", 5'b01010);
      rst = 1'b1;
      step(6'b000000);
      check("R1", 5'b00000);
      rst = 1'b0;
      step(6'b000000);
      check("R1", 5'b00000);     // stored pulse discarded
      step(6'b000000);
      check("R2", 5'b00000);

      // Lock held from the first cycle: arbitration lasts exactly one cycle (R4).
      step(6'b100100);
      check("R4", 5'b10000);
      step(6'b000100);
      check("R4", 5'b01010);
      step(6'b000001);           // data_rdy in address phase has no effect
      check("R5", 5'b01010);
      step(6'b000110);
      check("R12", 5'b00110);
      step(6'b000001);           // lock dropped at completion -> idle
      check("R7", 5'b00001);
      step(6'b000000);
      check("R7", 5'b00000);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule